// File: doc/BRIEF.md
# Strobed handshake port channel

This block is one 8-bit parallel data channel that moves bytes between a processor and an external device under a three-line handshake. A static direction input selects the role. As an input channel, the external device pulls its strobe low to load a byte. The block then reports the byte as waiting, and when the strobe is released it may raise an interrupt. As an output channel, a processor write loads the output latch and marks it as full. The device's low acknowledge frees the latch, and the release of the acknowledge may raise an interrupt.

The three handshake lines occupy the low bits of an 8-bit companion control port. Bit 0 carries the interrupt request. Bit 1 carries the buffer flag. Bit 2 is the strobe or acknowledge input. The interrupt enable has no register of its own. It is the bit-2 latch of the companion port, and it is changed with a single-bit set/reset command. Command bits 3 to 7 drive five plain output lines. The processor can poll a status byte that packs all of these bits.

External strobe and data pass through a synchronizer of `SYNC_STAGES` flops before any decision is taken. Processor strobes are synchronous to `clk`.

Top module: `strobe_port`

## Requirements
- R1: While reset is asserted and after it is released, the interrupt request is 0, the enable is 0, the spare lines are 0 and the buffer is empty. An empty buffer shows `hs_flag`=0 in input direction and `hs_flag`=1 in output direction.
- R2: In input direction (`dir_out`=0), a low level on `hs_stb_n` copies `ext_din` into the read register and sets `hs_flag` to 1 (buffer full). `cpu_rdata` returns the read register in input direction.
- R3: In input direction, the rising edge of `hs_stb_n` sets `hs_irq` only when the enable is 1. With the enable at 0, a strobe leaves `hs_irq` at 0.
- R4: In input direction, the first cycle of a `cpu_rd` pulse clears `hs_irq`. `hs_flag` stays 1 while `cpu_rd` is high and drops to 0 on the cycle after `cpu_rd` falls.
- R5: In output direction (`dir_out`=1), a `cpu_wr` cycle loads `cpu_wdata` onto `ext_dout`, drives `hs_flag` to 0 (output full, active low) and clears `hs_irq`. `cpu_wr` has no effect in input direction.
- R6: In output direction, a low level on `hs_stb_n` (acknowledge) returns `hs_flag` to 1. Its rising edge sets `hs_irq` when the enable is 1.
- R7: A set/reset command (`bsr_we` with `bsr_bit`, `bsr_set`) on bit 2 writes the enable. On bits 3 to 7 it writes `pc_spare[bsr_bit-3]`. On bits 0 and 1 it changes nothing.
- R8: `pc_rdata` bit 0 is `hs_irq`, bit 1 is `hs_flag`, bit 2 is the enable, and bits 7:3 are `pc_spare[4:0]`.
- R9: A change on `hs_stb_n` applied between clock edges becomes visible on `hs_flag` or `hs_irq` at the third rising edge after it, with the default `SYNC_STAGES`=2. It is not visible at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_out | input | 1 | Channel role: 0 input, 1 output |
| cpu_rd | input | 1 | Processor read strobe for the data register |
| cpu_wr | input | 1 | Processor write strobe for the output latch |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Read register (input role) or output latch (output role) |
| bsr_we | input | 1 | Single-bit set/reset command valid |
| bsr_bit | input | 3 | Companion-port bit addressed by the command |
| bsr_set | input | 1 | Value written by the command |
| pc_rdata | output | 8 | Packed status of the companion port |
| ext_din | input | DW | Data from the external device |
| ext_dout | output | DW | Data to the external device |
| hs_stb_n | input | 1 | Strobe (input role) or acknowledge (output role), active low |
| hs_flag | output | 1 | Buffer full (input role, high) or output full (output role, low) |
| hs_irq | output | 1 | Interrupt request |
| pc_spare | output | 5 | General-purpose lines driven by set/reset commands |

## Verification
The bench builds the block with its defaults, DW=8 and SYNC_STAGES=2. With these values the synchronizer latency is short and fixed, so the bench can pin the three-edge response of R9 to the exact cycle. The 8-bit width lets random bytes reach every data bit and every status position. Random transfers in both roles are mixed with direction changes while a flag is still pending, set/reset commands on the ignored low bits, and strobes taken with the enable cleared.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

  localparam int PC_W     = 8;
  localparam int SEL_W    = $clog2(PC_W);
  localparam int IRQ_POS  = 0;
  localparam int FLAG_POS = 1;
  localparam int STB_POS  = 2;
  localparam int SPARE_LO = 3;
  localparam int SPARE_W  = PC_W - SPARE_LO;

  typedef enum logic {
    CH_IN  = 1'b0,
    CH_OUT = 1'b1
  } ch_dir_e;

  // Pin level of the buffer flag: high-true full for input, low-true full for output.
  function automatic logic flag_pin(ch_dir_e d, logic full);
    return (d == CH_OUT) ? ~full : full;
  endfunction

  // Status byte seen by the processor.
  function automatic logic [PC_W-1:0] pack_status(logic [SPARE_W-1:0] spare,
                                                   logic inte, logic flag, logic irq);
    logic [PC_W-1:0] s;
    s = '0;
    s[IRQ_POS]  = irq;
    s[FLAG_POS] = flag;
    s[STB_POS]  = inte;
    s[PC_W-1:SPARE_LO] = spare;
    return s;
  endfunction

  // Next buffer-full state. Filling events win over draining events.
  function automatic logic full_next(ch_dir_e d, logic full, logic hs_low,
                                     logic rd_end, logic wr);
    if (d == CH_IN) begin
      if (hs_low)      return 1'b1;
      else if (rd_end) return 1'b0;
    end else begin
      if (wr)          return 1'b1;
      else if (hs_low) return 1'b0;
    end
    return full;
  endfunction

  // Next interrupt request. A qualified handshake release wins over the clearing access.
  function automatic logic irq_next(ch_dir_e d, logic irq, logic hs_rise, logic inte,
                                    logic rd_start, logic wr);
    if (hs_rise && inte) return 1'b1;
    if ((d == CH_IN) ? rd_start : wr) return 1'b0;
    return irq;
  endfunction

endpackage

// File: rtl/strobe_port_sync.sv
module strobe_port_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strobe_port_edge.sv
module strobe_port_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/strobe_port_bitcmd.sv
module strobe_port_bitcmd
  import strobe_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bsr_we,
  input  logic [SEL_W-1:0]   bsr_bit,
  input  logic               bsr_set,
  output logic               inte,
  output logic [SPARE_W-1:0] spare
);
  logic [SPARE_W-1:0] hit;

  for (genvar i = 0; i < SPARE_W; i++) begin : g_hit
    assign hit[i] = bsr_we && (bsr_bit == SEL_W'(SPARE_LO + i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inte  <= 1'b0;
      spare <= '0;
    end else begin
      if (bsr_we && bsr_bit == SEL_W'(STB_POS)) inte <= bsr_set;
      for (int i = 0; i < SPARE_W; i++)
        if (hit[i]) spare[i] <= bsr_set;
    end
  end
endmodule

// File: rtl/strobe_port_chan.sv
module strobe_port_chan
  import strobe_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ch_dir_e       dir,
  input  logic          hs_lvl,
  input  logic          hs_rise,
  input  logic          rd_start,
  input  logic          rd_end,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] din,
  input  logic          inte,
  output logic          full,
  output logic          irq,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] out_q
);
  logic hs_low;
  logic wr_act;

  assign hs_low = ~hs_lvl;
  assign wr_act = wr && (dir == CH_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      irq   <= 1'b0;
      in_q  <= '0;
      out_q <= '0;
    end else begin
      full <= full_next(dir, full, hs_low, rd_end, wr_act);
      irq  <= irq_next(dir, irq, hs_rise, inte, rd_start, wr_act);
      if (dir == CH_IN && hs_low) in_q  <= din;
      if (wr_act)                 out_q <= wdata;
    end
  end
endmodule

// File: rtl/strobe_port.sv
module strobe_port
  import strobe_port_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dir_out,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_rdata,
  input  logic               bsr_we,
  input  logic [SEL_W-1:0]   bsr_bit,
  input  logic               bsr_set,
  output logic [PC_W-1:0]    pc_rdata,
  input  logic [DW-1:0]      ext_din,
  output logic [DW-1:0]      ext_dout,
  input  logic               hs_stb_n,
  output logic               hs_flag,
  output logic               hs_irq,
  output logic [SPARE_W-1:0] pc_spare
);
  ch_dir_e       dir;
  logic          hs_lvl;
  logic [DW-1:0] din_s;
  logic          evt_hs_rise, evt_hs_fall;
  logic          evt_rd_start, evt_rd_end;
  logic          inte, full, irq;
  logic [DW-1:0] in_q, out_q;

  assign dir = ch_dir_e'(dir_out);

  strobe_port_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hs_sync (
    .clk(clk), .rst_n(rst_n), .d(hs_stb_n), .q(hs_lvl));

  strobe_port_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_din), .q(din_s));

  strobe_port_edge #(.RST_VAL(1'b1)) u_hs_edge (
    .clk(clk), .rst_n(rst_n), .lvl(hs_lvl), .rise(evt_hs_rise), .fall(evt_hs_fall));

  strobe_port_edge #(.RST_VAL(1'b0)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .lvl(cpu_rd), .rise(evt_rd_start), .fall(evt_rd_end));

  strobe_port_bitcmd u_bitcmd (
    .clk(clk), .rst_n(rst_n), .bsr_we(bsr_we), .bsr_bit(bsr_bit), .bsr_set(bsr_set),
    .inte(inte), .spare(pc_spare));

  strobe_port_chan #(.DW(DW)) u_chan (
    .clk(clk), .rst_n(rst_n), .dir(dir), .hs_lvl(hs_lvl), .hs_rise(evt_hs_rise),
    .rd_start(evt_rd_start), .rd_end(evt_rd_end), .wr(cpu_wr), .wdata(cpu_wdata),
    .din(din_s), .inte(inte), .full(full), .irq(irq), .in_q(in_q), .out_q(out_q));

  assign hs_flag   = flag_pin(dir, full);
  assign hs_irq    = irq;
  assign ext_dout  = out_q;
  assign cpu_rdata = (dir == CH_OUT) ? out_q : in_q;
  assign pc_rdata  = pack_status(pc_spare, inte, hs_flag, irq);
endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk
  import strobe_port_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_out,
  input logic             cpu_wr,
  input logic [DW-1:0]    cpu_wdata,
  input logic             bsr_we,
  input logic [SEL_W-1:0] bsr_bit,
  input logic             bsr_set,
  input logic             hs_lvl,
  input logic             evt_hs_rise,
  input logic             evt_hs_fall,
  input logic             evt_rd_start,
  input logic             evt_rd_end,
  input logic             inte,
  input logic             full,
  input logic             irq,
  input logic [DW-1:0]    ext_dout,
  input logic             hs_flag
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && !full && !inte));

  // R2
  fill_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && evt_hs_fall) |=> full);

  // R3
  irq_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && evt_hs_rise && inte) |=> irq);

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(evt_hs_rise && inte)) |=> !irq);

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && evt_rd_start && !evt_hs_rise) |=> !irq);

  // R4
  rd_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_out && evt_rd_end && hs_lvl) |=> !full);

  // R5
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_out && cpu_wr) |=> (ext_dout == $past(cpu_wdata) && (!dir_out || !hs_flag)));

  // R6
  ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_out && !hs_lvl && !cpu_wr) |=> (!dir_out || hs_flag));

  // R7
  inte_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_we && bsr_bit == SEL_W'(STB_POS)) |=> (inte == $past(bsr_set)));
endmodule

bind strobe_port strobe_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .bsr_we(bsr_we), .bsr_bit(bsr_bit), .bsr_set(bsr_set), .hs_lvl(hs_lvl),
  .evt_hs_rise(evt_hs_rise), .evt_hs_fall(evt_hs_fall), .evt_rd_start(evt_rd_start),
  .evt_rd_end(evt_rd_end), .inte(inte), .full(full), .irq(irq), .ext_dout(ext_dout),
  .hs_flag(hs_flag));

// File: tb/strobe_port_test.sv
module strobe_port_test;
  localparam int DW   = 8;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dir_out = 1'b0;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          bsr_we = 1'b0;
  logic [2:0]    bsr_bit = '0;
  logic          bsr_set = 1'b0;
  logic [7:0]    pc_rdata;
  logic [DW-1:0] ext_din = '0;
  logic [DW-1:0] ext_dout;
  logic          hs_stb_n = 1'b1;
  logic          hs_flag;
  logic          hs_irq;
  logic [4:0]    pc_spare;

  always #2 clk = ~clk;

  strobe_port #(.DW(DW), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bsr_we(bsr_we), .bsr_bit(bsr_bit),
    .bsr_set(bsr_set), .pc_rdata(pc_rdata), .ext_din(ext_din), .ext_dout(ext_dout),
    .hs_stb_n(hs_stb_n), .hs_flag(hs_flag), .hs_irq(hs_irq), .pc_spare(pc_spare));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the channel state
  logic          m_inte = 0, m_irq = 0, m_full = 0;
  logic [4:0]    m_spare = '0;
  logic [DW-1:0] m_in = '0, m_out = '0;

  function automatic logic m_flag();
    return dir_out ? !m_full : m_full;
  endfunction

  function automatic logic [7:0] m_status();
    return {m_spare, m_inte, m_flag(), m_irq};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    chk({tag, " irq"}, 32'(hs_irq), 32'(m_irq));
    chk({tag, " flag"}, 32'(hs_flag), 32'(m_flag()));
    chk({tag, " R8 status"}, 32'(pc_rdata), 32'(m_status()));
    chk({tag, " R5 dout"}, 32'(ext_dout), 32'(m_out));
    chk({tag, " rdata"}, 32'(cpu_rdata), 32'(dir_out ? m_out : m_in));
    chk({tag, " R7 spare"}, 32'(pc_spare), 32'(m_spare));
  endtask

  task automatic bsr(logic [2:0] b, logic v);
    bsr_we = 1'b1; bsr_bit = b; bsr_set = v;
    tick(1);
    bsr_we = 1'b0;
    tick(1);
    if (b == 3'd2) m_inte = v;
    else if (b >= 3'd3) m_spare[b - 3'd3] = v;
  endtask

  task automatic hs_pulse(logic [DW-1:0] d);
    ext_din = d;
    tick(1);
    hs_stb_n = 1'b0;
    tick(3);
    hs_stb_n = 1'b1;
    tick(SYNC + 3);
    if (!dir_out) begin m_in = d; m_full = 1'b1; end
    else m_full = 1'b0;
    if (m_inte) m_irq = 1'b1;
  endtask

  task automatic cpu_read(int len);
    cpu_rd = 1'b1;
    tick(1);
    if (!dir_out) begin
      m_irq = 1'b0;
      chk("R4 irq cleared at read start", 32'(hs_irq), 32'(0));
      chk("R4 flag held during read", 32'(hs_flag), 32'(m_full));
    end
    tick(len - 1);
    cpu_rd = 1'b0;
    tick(2);
    if (!dir_out) m_full = 1'b0;
  endtask

  task automatic cpu_write(logic [DW-1:0] d);
    cpu_wdata = d; cpu_wr = 1'b1;
    tick(1);
    cpu_wr = 1'b0;
    tick(1);
    if (dir_out) begin m_out = d; m_full = 1'b1; m_irq = 1'b0; end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20250611);
    tick(3);
    check_all("R1 in reset");
    rst_n = 1'b1;
    tick(2);
    check_all("R1 after reset");
    dir_out = 1'b1; tick(1);
    chk("R1 output empty flag", 32'(hs_flag), 32'(1));
    dir_out = 1'b0; tick(1);

    // R7 enable and spare lines
    bsr(3'd2, 1'b1);
    chk("R7 enable set", 32'(pc_rdata[2]), 32'(1));
    bsr(3'd5, 1'b1);
    check_all("R7 spare set");
    bsr(3'd5, 1'b0);

    // R2 / R3 input transfer with enable
    hs_pulse(8'hA5);
    check_all("R2 R3 strobe in");
    // R7 commands on bits 0 and 1 are ignored
    bsr(3'd0, 1'b0);
    bsr(3'd1, 1'b0);
    check_all("R7 low bits ignored");
    cpu_read(3);
    check_all("R4 after read");

    // R3 with enable cleared
    bsr(3'd2, 1'b0);
    hs_pulse(8'h3C);
    check_all("R3 enable off");
    cpu_read(1);

    // R9 latency of the synchronizer, R2 flag and R3 irq
    bsr(3'd2, 1'b1);
    ext_din = 8'h96; tick(1);
    hs_stb_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 flag not yet at edge 2", 32'(hs_flag), 32'(0));
    @(posedge clk); @(negedge clk);
    chk("R9 flag at edge 3", 32'(hs_flag), 32'(1));
    hs_stb_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 irq not yet at edge 2", 32'(hs_irq), 32'(0));
    @(posedge clk); @(negedge clk);
    chk("R9 irq at edge 3", 32'(hs_irq), 32'(1));
    m_in = 8'h96; m_full = 1'b1; m_irq = 1'b1;
    tick(2);
    check_all("R2 data latched");
    cpu_read(2);

    // R5 / R6 output role
    dir_out = 1'b1; tick(1);
    check_all("R1 output idle");
    cpu_write(8'h5A);
    check_all("R5 write");
    hs_pulse(8'h00);
    check_all("R6 ack");
    cpu_write(8'hC3);
    check_all("R5 write clears irq");
    hs_pulse(8'h00);
    dir_out = 1'b0; tick(1);
    cpu_write(8'hFF);
    check_all("R5 write ignored in input role");

    // Random mix
    for (int it = 0; it < 150; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: bsr(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        1: begin dir_out = ~dir_out; tick(1); end
        2: hs_pulse(8'($urandom));
        3: cpu_read($urandom_range(1, 3));
        4: cpu_write(8'($urandom));
        default: tick(2);
      endcase
      check_all(dir_out ? "R6 random out" : "R3 random in");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule